// File: doc/BRIEF.md
# Microengine Debug Halt Controller

This block is the run/halt state keeper for one small microengine under debug control. It records whether the engine is idle, running a thread, halted from idle, or halted in the middle of a thread. It reacts to halt requests, breakpoint hits, single-step commands, resume commands and forced-instruction commands. From that state it drives the fetch enable, the release of shared-memory arbitration, the gate on the timebase clocks, the freeze of input sampling, and the enable of the multiply/divide unit.

A visibility flag ties this engine to a second one. The flag can only be raised while both engines are halted. While it is raised, this engine stays halted, resumes are held back, and single-step commands are dropped. A resume that was held back takes effect by itself once the flag is lowered. The datapath, instruction memory and arbiter sit outside this block and are reduced to pulse and level signals.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, `state_o` is 01 (idle), `vis_o` is 0, `tcr_clk_en` and `pin_sample_en` are 1, `arb_release`, `fetch_en`, `prefetch_exec` and `force_exec` are 0.
- R2: `state_o` encodes 00 run, 01 idle, 10 halted-from-idle, 11 halted-in-thread. A `thread_start` pulse in idle gives run on the next cycle. A `thread_end` pulse in run (not a step cycle) gives idle.
- R3: A `halt_req` or `bkpt_hit` pulse gives 10 on the next cycle when the engine is idle, and 11 when it is running. Halt priority is above `thread_end`.
- R4: In both halted states `arb_release` is 1 and `fetch_en` is 0 from the first halted cycle. `fetch_en` is 1 exactly when the state is 00.
- R5: While halted, `tcr_clk_en` is 0 only if `stop_tcr_en` is 1, and `pin_sample_en` is 0 only if `stop_pins_en` is 1. Outside halt both are 1.
- R6: A `step_cmd` in state 11 with `vis_o` 0 and no resume gives exactly one cycle of state 00. The state then returns to 11, or to 10 if `thread_end` arrives in that cycle.
- R7: In state 10, `step_cmd` is ignored and the state stays 10. A `resume_cmd` with `vis_o` 0 returns the state to 01.
- R8: A `vis_set` pulse sets `vis_o` on the next cycle only when this engine is halted and `other_halted` is 1. A `vis_clr` pulse clears it and takes priority over `vis_set`.
- R9: While `vis_o` is 1, a halted engine stays halted, `step_cmd` is ignored, and `resume_cmd` is held back. The held resume exits halt one cycle after `vis_o` returns to 0.
- R10: Leaving state 11 for run, whether by resume or by step, raises `prefetch_exec` for the first run cycle only.
- R11: While halted, `mdu_en` equals `mdu_busy` unless `end_instr` was 1 at the cycle of halt entry, in which case it is 0. Outside halt `mdu_en` is 1.
- R12: A `force_cmd` pulse in either halted state raises `force_exec` for one cycle on the next cycle. Outside halt it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thread_start | input | 1 | Pulse: engine begins a thread |
| thread_end | input | 1 | Pulse: thread completes |
| halt_req | input | 1 | Pulse: debug halt request |
| bkpt_hit | input | 1 | Pulse: hardware breakpoint matched |
| step_cmd | input | 1 | Pulse: execute one microinstruction |
| resume_cmd | input | 1 | Pulse: leave halt |
| force_cmd | input | 1 | Pulse: run one forced instruction while halted |
| end_instr | input | 1 | Current instruction is an END |
| mdu_busy | input | 1 | Multiply/divide operation in progress |
| stop_tcr_en | input | 1 | Gate timebase clocks during halt |
| stop_pins_en | input | 1 | Freeze input sampling during halt |
| other_halted | input | 1 | Second engine is halted or stopped |
| vis_set | input | 1 | Pulse: request to raise the visibility flag |
| vis_clr | input | 1 | Pulse: lower the visibility flag |
| state_o | output | 2 | Engine state code |
| vis_o | output | 1 | Visibility flag |
| fetch_en | output | 1 | Fetch/execute enable |
| prefetch_exec | output | 1 | First run cycle after leaving halted-in-thread |
| force_exec | output | 1 | Execute the forced instruction |
| arb_release | output | 1 | Shared-memory arbitration released |
| tcr_clk_en | output | 1 | Timebase clock enable |
| pin_sample_en | output | 1 | Input sampling enable |
| mdu_en | output | 1 | Multiply/divide unit enable |

## Verification
The hardest case to reach is a resume that is held back by the visibility flag. To reach it, the engine must first be halted inside a thread. The second engine must then report halted, `vis_set` must be accepted, and both a step and a resume must arrive while the flag is high. Only then is the flag cleared. The stimulus walks this path in order and checks three things: the state holds through the cycle in which `vis_o` falls, the exit arrives one cycle later, and `prefetch_exec` pulses at that exit. A step whose cycle coincides with `thread_end` is also driven, to reach the landing in state 10.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    localparam int unsigned ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_RUN       = 2'b00,
        ST_IDLE      = 2'b01,
        ST_HALT_IDLE = 2'b10,
        ST_HALT_EXEC = 2'b11
    } eng_state_e;

    typedef struct packed {
        eng_state_e st;
        logic       step_act;
        logic       resume_pend;
        logic       end_lat;
        logic       pfx;
        logic       frc;
    } fsm_regs_t;
endpackage

// File: rtl/dbg_halt_vis.sv
module dbg_halt_vis (
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic other_halted,
    input  logic vis_set,
    input  logic vis_clr,
    output logic vis
);
    logic vis_d, vis_q;

    always_comb begin
        vis_d = vis_q;
        if (vis_clr)
            vis_d = 1'b0;
        else if (vis_set && halted && other_halted)
            vis_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vis_q <= 1'b0;
        else        vis_q <= vis_d;
    end

    assign vis = vis_q;
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
    import dbg_halt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       bkpt_hit,
    input  logic       step_cmd,
    input  logic       resume_cmd,
    input  logic       thread_start,
    input  logic       thread_end,
    input  logic       force_cmd,
    input  logic       end_instr,
    input  logic       vis,
    output eng_state_e state,
    output logic       end_lat,
    output logic       prefetch_exec,
    output logic       force_exec
);
    fsm_regs_t r_d, r_q;
    logic      halt_in;
    logic      leave_ok;

    assign halt_in  = halt_req | bkpt_hit;
    assign leave_ok = (resume_cmd | r_q.resume_pend) & ~vis;

    always_comb begin
        r_d          = r_q;
        r_d.pfx      = 1'b0;
        r_d.frc      = 1'b0;
        r_d.step_act = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (halt_in) begin
                    r_d.st          = ST_HALT_IDLE;
                    r_d.end_lat     = end_instr;
                    r_d.resume_pend = 1'b0;
                end else if (thread_start) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (halt_in) begin
                    r_d.st          = ST_HALT_EXEC;
                    r_d.end_lat     = end_instr;
                    r_d.resume_pend = 1'b0;
                end else if (r_q.step_act) begin
                    r_d.st          = thread_end ? ST_HALT_IDLE : ST_HALT_EXEC;
                    r_d.end_lat     = end_instr;
                    r_d.resume_pend = 1'b0;
                end else if (thread_end) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_HALT_IDLE: begin
                r_d.frc = force_cmd;
                if (leave_ok) begin
                    r_d.st          = ST_IDLE;
                    r_d.resume_pend = 1'b0;
                end else if (resume_cmd) begin
                    r_d.resume_pend = 1'b1;
                end
            end
            ST_HALT_EXEC: begin
                r_d.frc = force_cmd;
                if (leave_ok) begin
                    r_d.st          = ST_RUN;
                    r_d.resume_pend = 1'b0;
                    r_d.pfx         = 1'b1;
                end else if (resume_cmd) begin
                    r_d.resume_pend = 1'b1;
                end else if (step_cmd && !vis) begin
                    r_d.st       = ST_RUN;
                    r_d.step_act = 1'b1;
                    r_d.pfx      = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st          <= ST_IDLE;
            r_q.step_act    <= 1'b0;
            r_q.resume_pend <= 1'b0;
            r_q.end_lat     <= 1'b0;
            r_q.pfx         <= 1'b0;
            r_q.frc         <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state         = r_q.st;
    assign end_lat       = r_q.end_lat;
    assign prefetch_exec = r_q.pfx;
    assign force_exec    = r_q.frc;
endmodule

// File: rtl/dbg_halt_gates.sv
module dbg_halt_gates
    import dbg_halt_pkg::*;
(
    input  eng_state_e state,
    input  logic       end_lat,
    input  logic       mdu_busy,
    input  logic       stop_tcr_en,
    input  logic       stop_pins_en,
    output logic       halted,
    output logic       fetch_en,
    output logic       arb_release,
    output logic       tcr_clk_en,
    output logic       pin_sample_en,
    output logic       mdu_en
);
    always_comb begin
        halted        = (state == ST_HALT_IDLE) || (state == ST_HALT_EXEC);
        fetch_en      = (state == ST_RUN);
        arb_release   = halted;
        tcr_clk_en    = !(halted && stop_tcr_en);
        pin_sample_en = !(halted && stop_pins_en);
        mdu_en        = halted ? (mdu_busy && !end_lat) : 1'b1;
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            thread_start,
    input  logic            thread_end,
    input  logic            halt_req,
    input  logic            bkpt_hit,
    input  logic            step_cmd,
    input  logic            resume_cmd,
    input  logic            force_cmd,
    input  logic            end_instr,
    input  logic            mdu_busy,
    input  logic            stop_tcr_en,
    input  logic            stop_pins_en,
    input  logic            other_halted,
    input  logic            vis_set,
    input  logic            vis_clr,
    output logic [ST_W-1:0] state_o,
    output logic            vis_o,
    output logic            fetch_en,
    output logic            prefetch_exec,
    output logic            force_exec,
    output logic            arb_release,
    output logic            tcr_clk_en,
    output logic            pin_sample_en,
    output logic            mdu_en
);
    eng_state_e state;
    logic       end_lat;
    logic       halted;
    logic       vis;

    dbg_halt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req     (halt_req),
        .bkpt_hit     (bkpt_hit),
        .step_cmd     (step_cmd),
        .resume_cmd   (resume_cmd),
        .thread_start (thread_start),
        .thread_end   (thread_end),
        .force_cmd    (force_cmd),
        .end_instr    (end_instr),
        .vis          (vis),
        .state        (state),
        .end_lat      (end_lat),
        .prefetch_exec(prefetch_exec),
        .force_exec   (force_exec)
    );

    dbg_halt_gates u_gates (
        .state        (state),
        .end_lat      (end_lat),
        .mdu_busy     (mdu_busy),
        .stop_tcr_en  (stop_tcr_en),
        .stop_pins_en (stop_pins_en),
        .halted       (halted),
        .fetch_en     (fetch_en),
        .arb_release  (arb_release),
        .tcr_clk_en   (tcr_clk_en),
        .pin_sample_en(pin_sample_en),
        .mdu_en       (mdu_en)
    );

    dbg_halt_vis u_vis (
        .clk         (clk),
        .rst_n       (rst_n),
        .halted      (halted),
        .other_halted(other_halted),
        .vis_set     (vis_set),
        .vis_clr     (vis_clr),
        .vis         (vis)
    );

    assign state_o = state;
    assign vis_o   = vis;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       thread_end,
    input logic       halt_req,
    input logic       bkpt_hit,
    input logic       step_cmd,
    input logic       resume_cmd,
    input logic       force_cmd,
    input logic       other_halted,
    input logic [1:0] state_o,
    input logic       vis_o,
    input logic       fetch_en,
    input logic       force_exec,
    input logic       arb_release
);
    // R3: halt from idle lands in halted-from-idle
    p_idle_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && (halt_req || bkpt_hit)) |=> (state_o == 2'b10));

    // R3: halt from run lands in halted-in-thread
    p_run_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && (halt_req || bkpt_hit)) |=> (state_o == 2'b11));

    // R4: arbitration released and fetch stopped on the first halted cycle
    p_halt_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && halt_req) |=> (arb_release && !fetch_en));

    // R6: one run cycle, then halted again
    p_step_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && step_cmd && !vis_o && !$fell(vis_o) && !resume_cmd)
        |=> (state_o == 2'b00) ##1 state_o[1]);

    // R7: halted-from-idle never enters run
    p_hidle_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10) |=> (state_o == 2'b10 || state_o == 2'b01));

    // R8: flag rises only when both engines were halted
    p_vis_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vis_o) |-> $past(other_halted && state_o[1]));

    // R9: flag holds the engine halted
    p_vis_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o[1] && vis_o) |=> state_o[1]);

    // R12: forced command accepted while halted
    p_force_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o[1] && force_cmd) |=> force_exec);

    // R12: forced command ignored outside halt
    p_force_ign_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_o[1] && force_cmd) |=> !force_exec);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk u_chk (.*);

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
    localparam logic [8:0] C_NONE  = 9'h000;
    localparam logic [8:0] C_HALT  = 9'h001;
    localparam logic [8:0] C_BKPT  = 9'h002;
    localparam logic [8:0] C_STEP  = 9'h004;
    localparam logic [8:0] C_RES   = 9'h008;
    localparam logic [8:0] C_START = 9'h010;
    localparam logic [8:0] C_END   = 9'h020;
    localparam logic [8:0] C_VSET  = 9'h040;
    localparam logic [8:0] C_VCLR  = 9'h080;
    localparam logic [8:0] C_FRC   = 9'h100;

    localparam logic [1:0] S_RUN = 2'b00;
    localparam logic [1:0] S_IDL = 2'b01;
    localparam logic [1:0] S_HID = 2'b10;
    localparam logic [1:0] S_HEX = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thread_start = 0, thread_end = 0, halt_req = 0, bkpt_hit = 0;
    logic step_cmd = 0, resume_cmd = 0, force_cmd = 0, end_instr = 0;
    logic mdu_busy = 0, stop_tcr_en = 0, stop_pins_en = 0, other_halted = 0;
    logic vis_set = 0, vis_clr = 0;
    logic [1:0] state_o;
    logic vis_o, fetch_en, prefetch_exec, force_exec, arb_release;
    logic tcr_clk_en, pin_sample_en, mdu_en;

    int  checks = 0;
    int  fails  = 0;
    bit  b_end  = 0;
    bit  done   = 0;

    typedef struct {
        string      req;
        logic [9:0] v;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    dbg_halt_ctrl u_dbg_halt_ctrl (.*);

    task automatic tick(input logic [8:0] c);
        @(negedge clk);
        {force_cmd, vis_clr, vis_set, thread_end, thread_start,
         resume_cmd, step_cmd, bkpt_hit, halt_req} = c;
        @(posedge clk);
    endtask

    task automatic set_lvl(input logic tcr, input logic pins, input logic busy,
                           input logic endi, input logic oth);
        @(negedge clk);
        {force_cmd, vis_clr, vis_set, thread_end, thread_start,
         resume_cmd, step_cmd, bkpt_hit, halt_req} = '0;
        stop_tcr_en  = tcr;
        stop_pins_en = pins;
        mdu_busy     = busy;
        end_instr    = endi;
        other_halted = oth;
    endtask

    task automatic expect_st(input string req, input logic [1:0] st,
                             input logic vis, input logic pfx, input logic frc);
        exp_t e;
        logic h;
        h = st[1];
        e.req = req;
        e.v = {st, h, (st == S_RUN), !(h && stop_tcr_en), !(h && stop_pins_en),
               vis, (h ? (mdu_busy && !b_end) : 1'b1), pfx, frc};
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        logic [9:0] act;
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                e = q.pop_front();
                act = {state_o, arb_release, fetch_en, tcr_clk_en, pin_sample_en,
                       vis_o, mdu_en, prefetch_exec, force_exec};
                checks++;
                if (act !== e.v) begin
                    fails++;
                    $display("FAIL %s actual=%b expected=%b", e.req, act, e.v);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tick(C_NONE);  expect_st("R1 reset", S_IDL, 0, 0, 0);
        tick(C_START); expect_st("R2 start", S_RUN, 0, 0, 0);
        tick(C_NONE);  expect_st("R2 run hold", S_RUN, 0, 0, 0);
        tick(C_END);   expect_st("R2 end", S_IDL, 0, 0, 0);

        set_lvl(1, 0, 0, 0, 0); b_end = 0;
        tick(C_HALT);  expect_st("R3 R4 R5 halt idle", S_HID, 0, 0, 0);
        tick(C_STEP);  expect_st("R7 step refused", S_HID, 0, 0, 0);
        tick(C_FRC);   expect_st("R12 force", S_HID, 0, 0, 1);
        tick(C_NONE);  expect_st("R12 force pulse", S_HID, 0, 0, 0);
        tick(C_RES);   expect_st("R7 resume idle", S_IDL, 0, 0, 0);
        tick(C_FRC);   expect_st("R12 force ignored", S_IDL, 0, 0, 0);

        set_lvl(0, 1, 1, 0, 0); b_end = 0;
        tick(C_START); expect_st("R2 start again", S_RUN, 0, 0, 0);
        tick(C_BKPT);  expect_st("R3 R5 R11 bkpt", S_HEX, 0, 0, 0);
        tick(C_STEP);  expect_st("R6 R10 step run", S_RUN, 0, 1, 0);
        tick(C_NONE);  expect_st("R6 step back", S_HEX, 0, 0, 0);
        tick(C_RES);   expect_st("R10 resume", S_RUN, 0, 1, 0);
        tick(C_NONE);  expect_st("R10 pfx pulse", S_RUN, 0, 0, 0);

        set_lvl(0, 1, 1, 1, 0); b_end = 1;
        tick(C_HALT);  expect_st("R11 halt on end", S_HEX, 0, 0, 0);
        set_lvl(0, 1, 1, 0, 0);
        tick(C_VSET);  expect_st("R8 vis refused", S_HEX, 0, 0, 0);
        set_lvl(0, 1, 1, 0, 1);
        tick(C_VSET);  expect_st("R8 vis set", S_HEX, 1, 0, 0);
        tick(C_STEP);  expect_st("R9 step ignored", S_HEX, 1, 0, 0);
        tick(C_RES);   expect_st("R9 resume held", S_HEX, 1, 0, 0);
        tick(C_NONE);  expect_st("R9 still halted", S_HEX, 1, 0, 0);
        tick(C_VCLR);  expect_st("R9 vis cleared", S_HEX, 0, 0, 0);
        tick(C_NONE);  expect_st("R9 R10 auto exit", S_RUN, 0, 1, 0);
        tick(C_NONE);  expect_st("R9 run", S_RUN, 0, 0, 0);
        tick(C_VSET);  expect_st("R8 vis refused running", S_RUN, 0, 0, 0);

        b_end = 0;
        tick(C_HALT);  expect_st("R3 R11 halt busy", S_HEX, 0, 0, 0);
        set_lvl(0, 1, 0, 0, 1);
        tick(C_NONE);  expect_st("R11 mdu done", S_HEX, 0, 0, 0);
        tick(C_VSET | C_VCLR); expect_st("R8 clr priority", S_HEX, 0, 0, 0);
        tick(C_RES);   expect_st("R10 resume", S_RUN, 0, 1, 0);
        tick(C_HALT);  expect_st("R3 R4 halt run", S_HEX, 0, 0, 0);
        tick(C_STEP);  expect_st("R6 step", S_RUN, 0, 1, 0);
        tick(C_END);   expect_st("R6 step ends thread", S_HID, 0, 0, 0);
        tick(C_RES);   expect_st("R7 resume idle", S_IDL, 0, 0, 0);
        tick(C_NONE);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule